// File: doc/BRIEF.md
# Three-Level Page Table Walker

This unit turns a 64-bit virtual address into a 56-bit physical address. It walks a radix page table of three levels that is stored in a memory of 64-bit words. A requester offers a translation through a valid/ready handshake. The request carries the virtual address, a 64-bit translation control word and a flag that marks machine mode. In the control word, bit 63 enables translation and bits 43:0 hold the page number of the root table.

When translation is off, or the requester is in machine mode, the address passes straight through and no memory is touched. Otherwise the walker reads one table entry per level and stops at the first leaf. It then builds the physical address for a 1 GiB, 2 MiB or 4 KiB page, or it reports a page fault. The memory port has one read in flight at a time. The response stays on the outputs until the requester takes it.

Top module: `vm_walker3`

## Requirements
- R1: When control bit 63 is 0, the response comes in the cycle after acceptance. It carries paddr = vaddr[55:0] and fault = 0, and no memory read is issued.
- R2: When machine mode is flagged, the same pass-through as R1 applies even if control bit 63 is 1.
- R3: The virtual page fields are vaddr[38:30] for level 2, [29:21] for level 1 and [20:12] for level 0. The walk starts at level 2. Its first read uses word index {ctrl[43:0], vaddr[38:30]}, which is the root byte address plus field times 8, shifted right by 3.
- R4: A valid entry that is not a leaf gives the next word index {pte[53:10], next-level field}. Exactly one read pulse is issued per level. No new read is issued until mem_rd_valid has returned the previous one, and there are at most three reads per walk.
- R5: An entry is a leaf when R (bit 1) or X (bit 3) is set. A leaf at level 0 gives paddr = {pte[53:10], vaddr[11:0]}.
- R6: A leaf at level 1 gives paddr = {pte[53:19], vaddr[20:0]}. It faults when pte[18:10] is not zero.
- R7: A leaf at level 2 gives paddr = {pte[53:28], vaddr[29:0]}. It faults when pte[27:10] is not zero.
- R8: An entry with V (bit 0) clear, or with W (bit 2) set and R clear, ends the walk with a fault. Every faulting response has paddr = 0.
- R9: An entry that is valid but not a leaf at level 0 ends the walk with a fault.
- R10: req_ready is high only while the unit is idle. rsp_valid, rsp_paddr and rsp_fault hold steady until rsp_ready is seen, and the unit is idle again in the next cycle.
- R11: Synchronous reset, even in the middle of a walk, returns the unit to idle: req_ready = 1, rsp_valid = 0, mem_rd_en = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Unit idle and able to accept a request |
| req_vaddr | input | 64 | Virtual address |
| req_ctrl | input | 64 | Control word: bit 63 enable, bits 43:0 root page number |
| req_mmode | input | 1 | Requester runs in machine mode |
| mem_rd_en | output | 1 | One-cycle read request pulse |
| mem_rd_idx | output | 53 | Word index of the table entry to read |
| mem_rd_valid | input | 1 | Read data is present |
| mem_rd_data | input | 64 | Table entry read from memory |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_paddr | output | 56 | Physical address, zero on fault |
| rsp_fault | output | 1 | Page fault |

## Verification
The response handshake and the request handshake can both be live in the same cycle: a requester may offer its next address while the previous result is still waiting. The bench provokes this by holding a new request on the inputs during a held response. It checks that req_ready stays low until the response is taken, and that the new request is then accepted and answered with its own address. A walk cut short by reset is also judged at the ports. The bench covers every combination of the four low entry flags at each of the three levels, with both aligned and misaligned page numbers.

// File: rtl/vm_walker3.sv
module vm_walker3 #(
  parameter int XLEN  = 64,
  parameter int PPN_W = 44
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [XLEN-1:0]      req_vaddr,
  input  logic [XLEN-1:0]      req_ctrl,
  input  logic                 req_mmode,
  output logic                 mem_rd_en,
  output logic [PPN_W+8:0]     mem_rd_idx,
  input  logic                 mem_rd_valid,
  input  logic [XLEN-1:0]      mem_rd_data,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [PPN_W+11:0]    rsp_paddr,
  output logic                 rsp_fault
);
  localparam int PA_W  = PPN_W + 12;
  localparam int VA_HI = 38;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_RESP} state_t;

  state_t            state;
  logic [1:0]        lvl;
  logic [PPN_W-1:0]  base;
  logic [VA_HI:0]    va_q;
  logic [PA_W-1:0]   pa_q;
  logic              fault_q;

  logic [8:0]        vpn;
  logic [PPN_W-1:0]  ppn;
  logic              pv, pr, pw, px, leaf, bad, misal;
  logic [PA_W-1:0]   leaf_pa;
  logic              bypass;

  assign bypass = ~req_ctrl[XLEN-1] | req_mmode;

  assign vpn = (lvl == 2'd2) ? va_q[38:30] :
               (lvl == 2'd1) ? va_q[29:21] : va_q[20:12];

  assign ppn  = mem_rd_data[PPN_W+9:10];
  assign pv   = mem_rd_data[0];
  assign pr   = mem_rd_data[1];
  assign pw   = mem_rd_data[2];
  assign px   = mem_rd_data[3];
  assign leaf = pr | px;
  assign bad  = ~pv | (pw & ~pr);
  assign misal = ((lvl == 2'd2) && (ppn[17:0] != '0)) ||
                 ((lvl == 2'd1) && (ppn[8:0]  != '0));

  always_comb begin
    case (lvl)
      2'd2:    leaf_pa = {ppn[PPN_W-1:18], va_q[29:0]};
      2'd1:    leaf_pa = {ppn[PPN_W-1:9],  va_q[20:0]};
      default: leaf_pa = {ppn,             va_q[11:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      lvl     <= 2'd0;
      base    <= '0;
      va_q    <= '0;
      pa_q    <= '0;
      fault_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va_q <= req_vaddr[VA_HI:0];
          if (bypass) begin
            pa_q    <= req_vaddr[PA_W-1:0];
            fault_q <= 1'b0;
            state   <= S_RESP;
          end else begin
            base  <= req_ctrl[PPN_W-1:0];
            lvl   <= 2'd2;
            state <= S_ISSUE;
          end
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: if (mem_rd_valid) begin
          if (bad || (leaf && misal) || (!leaf && lvl == 2'd0)) begin
            pa_q    <= '0;
            fault_q <= 1'b1;
            state   <= S_RESP;
          end else if (leaf) begin
            pa_q    <= leaf_pa;
            fault_q <= 1'b0;
            state   <= S_RESP;
          end else begin
            base  <= ppn;
            lvl   <= lvl - 2'd1;
            state <= S_ISSUE;
          end
        end
        S_RESP: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (state == S_IDLE);
  assign mem_rd_en  = (state == S_ISSUE);
  assign mem_rd_idx = {base, vpn};
  assign rsp_valid  = (state == S_RESP);
  assign rsp_paddr  = pa_q;
  assign rsp_fault  = fault_q;

  logic unused_bits;
  assign unused_bits = ^{mem_rd_data[XLEN-1:PPN_W+10], mem_rd_data[9:4],
                         req_ctrl[XLEN-2:PPN_W], req_vaddr[XLEN-1:PA_W]};
endmodule

// File: rtl/vm_walker3_chk.sv
module vm_walker3_chk #(
  parameter int XLEN  = 64,
  parameter int PPN_W = 44
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [XLEN-1:0]   req_vaddr,
  input logic [XLEN-1:0]   req_ctrl,
  input logic              req_mmode,
  input logic              mem_rd_en,
  input logic [PPN_W+8:0]  mem_rd_idx,
  input logic              mem_rd_valid,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [PPN_W+11:0] rsp_paddr,
  input logic              rsp_fault
);
  logic       pend;
  logic [2:0] rd_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= 1'b0;
      rd_cnt <= 3'd0;
    end else begin
      if (mem_rd_en) pend <= 1'b1;
      else if (mem_rd_valid) pend <= 1'b0;
      if (req_valid && req_ready) rd_cnt <= 3'd0;
      else if (mem_rd_en) rd_cnt <= rd_cnt + 3'd1;
    end
  end

  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

  a_r4_one_outstanding: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> !pend);

  a_r4_read_limit: assert property (@(posedge clk) disable iff (rst)
    rd_cnt <= 3'd3);

  a_r1_bypass: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && (!req_ctrl[XLEN-1] || req_mmode) |=>
      rsp_valid && !rsp_fault && rsp_paddr == $past(req_vaddr[PPN_W+11:0]));

  a_r3_first_read: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && req_ctrl[XLEN-1] && !req_mmode |=>
      mem_rd_en && mem_rd_idx == $past({req_ctrl[PPN_W-1:0], req_vaddr[38:30]}));

  a_r8_fault_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> rsp_paddr == '0);
endmodule

bind vm_walker3 vm_walker3_chk #(.XLEN(XLEN), .PPN_W(PPN_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .req_ctrl(req_ctrl), .req_mmode(req_mmode),
  .mem_rd_en(mem_rd_en), .mem_rd_idx(mem_rd_idx), .mem_rd_valid(mem_rd_valid),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
  .rsp_fault(rsp_fault)
);

// File: tb/vm_walker3_test.sv
`timescale 1ns/1ps
module vm_walker3_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        req_valid = 0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [63:0] req_ctrl = '0;
  logic        req_mmode = 0;
  logic        mem_rd_en;
  logic [52:0] mem_rd_idx;
  logic        mem_rd_valid = 0;
  logic [63:0] mem_rd_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 0;
  logic [55:0] rsp_paddr;
  logic        rsp_fault;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  vm_walker3 uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_ctrl(req_ctrl), .req_mmode(req_mmode),
    .mem_rd_en(mem_rd_en), .mem_rd_idx(mem_rd_idx), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog: run did not end, actual=%0d expected<=100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [63:0] va, input logic [63:0] ct, input logic mm,
                     input logic [63:0] q0, input logic [63:0] q1, input logic [63:0] q2,
                     input int lat);
    logic [63:0] ex_idx [3];
    logic [63:0] base, vpn, ppn, p;
    logic [55:0] epa;
    logic        ef, done;
    string       t;
    int          en, n, guard, lv;
    en = 0; ef = 0; epa = '0; t = "R1"; done = 0;
    ex_idx[0] = '0; ex_idx[1] = '0; ex_idx[2] = '0;
    if (!ct[63] || mm) begin
      epa = va[55:0];
      t = mm ? "R2" : "R1";
    end else begin
      base = {20'b0, ct[43:0]};
      for (int s = 0; s < 3; s++) begin
        if (!done) begin
          lv = 2 - s;
          vpn = (va >> (12 + 9 * lv)) & 64'h1ff;
          ex_idx[s] = (base << 9) | vpn;
          en++;
          p = (s == 0) ? q0 : (s == 1) ? q1 : q2;
          ppn = (p >> 10) & ((64'h1 << 44) - 1);
          if (!p[0] || (p[2] && !p[1])) begin
            ef = 1; t = "R8"; done = 1;
          end else if (p[1] || p[3]) begin
            done = 1;
            t = (lv == 2) ? "R7" : (lv == 1) ? "R6" : "R5";
            if ((ppn & ((64'h1 << (9 * lv)) - 1)) != 0) ef = 1;
            else epa = 56'((ppn << 12) | (va & ((64'h1 << (12 + 9 * lv)) - 1)));
          end else if (lv == 0) begin
            ef = 1; t = "R9"; done = 1;
          end else begin
            base = ppn;
          end
        end
      end
    end

    req_vaddr = va; req_ctrl = ct; req_mmode = mm; req_valid = 1;
    chk(req_ready == 1'b1, "R10 ready when idle", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 0;
    n = 0; guard = 0;
    while (!rsp_valid && guard < 40) begin
      if (mem_rd_en) begin
        chk(n < en, "R4 read count", 64'(n), 64'(en));
        chk(64'(mem_rd_idx) == ex_idx[n % 3], (n == 0) ? "R3 first index" : "R4 next index",
            64'(mem_rd_idx), ex_idx[n % 3]);
        for (int j = 0; j < lat; j++) begin
          @(negedge clk);
          chk(!mem_rd_en, "R4 no read while outstanding", 64'(mem_rd_en), 64'd0);
        end
        mem_rd_valid = 1;
        mem_rd_data = (n == 0) ? q0 : (n == 1) ? q1 : q2;
        @(negedge clk);
        mem_rd_valid = 0;
        n++;
      end else begin
        @(negedge clk);
      end
      guard++;
    end
    chk(n == en, {t, " reads per walk"}, 64'(n), 64'(en));
    chk(rsp_paddr == epa, {t, " paddr"}, 64'(rsp_paddr), 64'(epa));
    chk(rsp_fault == ef, {t, " fault"}, 64'(rsp_fault), 64'(ef));
    @(negedge clk);
    chk(rsp_valid && rsp_paddr == epa && rsp_fault == ef && !req_ready, "R10 hold",
        {7'b0, rsp_valid, rsp_paddr}, {8'h01, epa});
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    chk(!rsp_valid && req_ready, "R10 release", {62'b0, rsp_valid, req_ready}, 64'd1);
  endtask

  initial begin
    logic [63:0] va, ct, ptr, tgt, flg, lf, q0, q1, q2;
    int k;
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_rd_en, "R11 reset state",
        {61'b0, req_ready, rsp_valid, mem_rd_en}, 64'd4);
    rst = 0;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      va = 64'(i + 1) * 64'h9E37_79B9_7F4A_7C15;
      run(va, {1'b0, va[62:0]}, 1'b0, '0, '0, '0, 1);
      run(va, {1'b1, 19'b0, 44'(i * 7 + 3)}, 1'b1, '0, '0, '0, 1);
    end

    k = 0;
    for (int lvl = 0; lvl < 3; lvl++) begin
      for (int f = 0; f < 16; f++) begin
        for (int a = 0; a < 2; a++) begin
          va  = 64'(k + 5) * 64'h6C8E_9CF5_7093_2BD5;
          ct  = {1'b1, 19'b0, 44'(k * 37 + 5)};
          ptr = (64'(k * 1013 + 17) << 10) | 64'h1;
          tgt = ((64'(k + 1) << 18) | 64'(a)) << 10 | 64'(f);
          lf  = ((64'(k + 3) << 18) << 10) | 64'hB;
          q0 = (lvl == 2) ? tgt : ptr;
          q1 = (lvl == 1) ? tgt : (lvl == 2) ? lf : ((ptr + 64'h400) | 64'h1);
          q2 = (lvl == 0) ? tgt : lf;
          run(va, ct, 1'b0, q0, q1, q2, 1 + (k % 3));
          k++;
        end
      end
    end

    // response held while a new request waits (R10)
    req_vaddr = 64'h0000_00AB_CDEF_1234; req_ctrl = '0; req_mmode = 0; req_valid = 1;
    @(negedge clk);
    req_vaddr = 64'h0000_0012_3456_7000;
    chk(rsp_valid && !req_ready, "R10 new request blocked", {62'b0, rsp_valid, req_ready}, 64'd2);
    @(negedge clk);
    chk(rsp_valid && !req_ready && rsp_paddr == 56'h00_00AB_CDEF_1234, "R10 first result held",
        64'(rsp_paddr), 64'h0000_00AB_CDEF_1234);
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    chk(!rsp_valid && req_ready, "R10 idle after take", {62'b0, rsp_valid, req_ready}, 64'd1);
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid && rsp_paddr == 56'h00_0012_3456_7000, "R1 queued request served",
        64'(rsp_paddr), 64'h0000_0012_3456_7000);
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;

    // reset in the middle of a walk (R11)
    req_vaddr = 64'h0000_0040_1020_3456; req_ctrl = {1'b1, 63'h99}; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(mem_rd_en, "R3 walk started", 64'(mem_rd_en), 64'd1);
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_rd_en, "R11 reset mid walk",
        {61'b0, req_ready, rsp_valid, mem_rd_en}, 64'd4);
    rst = 0;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_rd_en, "R11 idle after reset",
        {61'b0, req_ready, rsp_valid, mem_rd_en}, 64'd4);
    run(64'h0000_0000_4000_5123, {1'b1, 19'b0, 44'h12},  1'b0,
        64'h0000_0000_0000_1001, 64'h0000_0000_0000_2001, 64'h0000_0000_0ABC_D00F, 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule